// File: doc/BRIEF.md
# Masked-Write GPIO Port Register Bank

This block holds the pin control state for one or more banks of general-purpose pins. Each bank has four ports, and each port has eight pins. Every port has three writable 8-bit registers: an enable (configuration) register, a drive-enable register and an output-value register. A read-only register returns the synchronized pad levels.

Each writable register can be reached at two addresses. A write to the direct address replaces the whole register. A write to the alias address, which sits 0x800 bytes above the direct one, changes only the pins chosen by a mask byte. Software can therefore flip a single pin without a read-modify-write sequence, and no lock is needed between agents that share a port.

The bus side is a plain word-addressed register port. A write commits on the clock edge. A read returns data combinationally from the current address. The pin side carries a value vector, an enable vector and an input vector, one bit per pin. Pin `k` of the block is port `k/8`, bit `k%8`.

Top module: `gpio_mw_bank`

## Requirements
- R1: After reset, every enable, drive-enable and output-value register reads 0x00, and `pad_oe_o` is all zeros.
- R2: A direct write replaces all 8 bits of the addressed register with `wdata_i[7:0]`. The new value is visible on a read in the cycle after the write edge.
- R3: A write to an alias updates only the pins whose bit in `wdata_i[15:8]` is 1. Each such pin takes the matching bit of `wdata_i[7:0]`, and every other pin keeps its value. Reading an alias address returns the same data as the direct register.
- R4: Addressing uses the byte offset `bank*0x80 + port*4 + kind*0x10`, with `addr_i` equal to that offset divided by 4. The kind codes are 0 for enable, 1 for drive-enable, 2 for output value and 3 for input. The alias flag adds 0x800. A write changes no register other than the one addressed.
- R5: `pad_out_o` carries each port's output-value register. `pad_oe_o` is 1 for a pin only when both its enable bit and its drive-enable bit are 1.
- R6: A read of the input register returns the pad levels through a two-flop synchronizer. A change on `pad_in_i` shows up after the second rising edge, and not after the first. Writes to the input offset have no effect.
- R7: Unmapped offsets read as zero, and writes to them change nothing. These are kind codes 4 to 7, a bank at or above `NUM_BANKS`, and the alias of the input register.
- R8: Bits [31:8] of `rdata_o` are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, commits on the rising edge |
| addr_i | input | ADDR_W (10) | Word address (byte offset divided by 4) |
| wdata_i | input | 16 | Write data: [15:8] is the mask on alias writes, [7:0] is the value |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| pad_out_o | output | NUM_BANKS*32 | Per-pin output value |
| pad_oe_o | output | NUM_BANKS*32 | Per-pin pad drive enable |
| pad_in_i | input | NUM_BANKS*32 | Per-pin pad level, asynchronous |

## Verification
Register writes become visible one edge after the write strobe. The bench drives each write on a falling edge and reads it back at the next falling edge, so exactly one rising edge has passed. `pad_out_o` and `pad_oe_o` follow the registers with no extra register, so the bench checks them in that same window. Input changes take two rising edges. The bench reads the input register after the first edge, where it expects the old level, and again after the second edge, where it expects the new level.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int PINS_PER_PORT  = 8;
  localparam int PORTS_PER_BANK = 4;

  typedef enum logic [2:0] {
    REG_CFG  = 3'd0,
    REG_OE   = 3'd1,
    REG_OUT  = 3'd2,
    REG_IN   = 3'd3,
    REG_NONE = 3'd7
  } reg_kind_e;

  // alias: [15:8] mask, [7:0] value; direct: whole byte
  function automatic logic [7:0] apply_wr(input logic [7:0] old_v,
                                          input logic [15:0] wd,
                                          input logic alias_wr);
    if (alias_wr) return (old_v & ~wd[15:8]) | (wd[7:0] & wd[15:8]);
    else          return wd[7:0];
  endfunction
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS  = 2,
  parameter int ADDR_W     = 10,
  parameter int PORT_IDX_W = 3
) (
  input  logic [ADDR_W-1:0]     addr_i,
  output reg_kind_e             kind_o,
  output logic                  alias_o,
  output logic [PORT_IDX_W-1:0] port_o
);
  localparam int BANK_W = ADDR_W - 6;

  logic [BANK_W-1:0] bank;
  logic [2:0]        sel;
  logic [1:0]        port_in_bank;

  assign alias_o      = addr_i[ADDR_W-1];
  assign bank         = addr_i[ADDR_W-2:5];
  assign sel          = addr_i[4:2];
  assign port_in_bank = addr_i[1:0];
  assign port_o       = PORT_IDX_W'({bank, port_in_bank});

  always_comb begin
    kind_o = REG_NONE;
    if (32'(bank) < NUM_BANKS) begin
      unique case (sel)
        3'd0:    kind_o = REG_CFG;
        3'd1:    kind_o = REG_OE;
        3'd2:    kind_o = REG_OUT;
        3'd3:    kind_o = alias_o ? REG_NONE : REG_IN;
        default: kind_o = REG_NONE;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_bank_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  reg_kind_e   kind_i,
  input  logic        alias_i,
  input  logic [15:0] wdata_i,
  output logic [7:0]  cfg_o,
  output logic [7:0]  oe_o,
  output logic [7:0]  out_o
);
  logic [7:0] cfg_q, oe_q, out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      oe_q  <= '0;
      out_q <= '0;
    end else if (wr_i) begin
      if (kind_i == REG_CFG) cfg_q <= apply_wr(cfg_q, wdata_i, alias_i);
      if (kind_i == REG_OE)  oe_q  <= apply_wr(oe_q,  wdata_i, alias_i);
      if (kind_i == REG_OUT) out_q <= apply_wr(out_q, wdata_i, alias_i);
    end
  end

  assign cfg_o = cfg_q;
  assign oe_o  = oe_q;
  assign out_o = out_q;

  AST_DIRECT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !alias_i && kind_i == REG_CFG) |=> cfg_q == $past(wdata_i[7:0])); // R2
  AST_MASK_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && alias_i && kind_i == REG_OUT) |=>
      ((out_q ^ $past(out_q)) & ~$past(wdata_i[15:8])) == 8'h00); // R3
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ($stable(cfg_q) && $stable(oe_q) && $stable(out_q))); // R4
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;
  logic [1:0]       age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= '0;
      s2_q  <= '0;
      age_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end
  end

  assign q_o = s2_q;

  AST_SYNC_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3) |-> s2_q == $past(d_i, 2)); // R6
endmodule

// File: rtl/gpio_mw_bank.sv
module gpio_mw_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 10
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [15:0]           wdata_i,
  output logic [31:0]           rdata_o,
  output logic [NUM_BANKS*32-1:0] pad_out_o,
  output logic [NUM_BANKS*32-1:0] pad_oe_o,
  input  logic [NUM_BANKS*32-1:0] pad_in_i
);
  localparam int NUM_PORTS  = NUM_BANKS * PORTS_PER_BANK;
  localparam int NUM_PINS   = NUM_PORTS * PINS_PER_PORT;
  localparam int PORT_IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  reg_kind_e             kind;
  logic                  alias_wr;
  logic [PORT_IDX_W-1:0] pidx;
  logic [7:0]            cfg_a [NUM_PORTS];
  logic [7:0]            oe_a  [NUM_PORTS];
  logic [7:0]            out_a [NUM_PORTS];
  logic [NUM_PINS-1:0]   in_sync;

  gpio_addr_dec #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .PORT_IDX_W(PORT_IDX_W)
  ) u_dec (
    .addr_i (addr_i),
    .kind_o (kind),
    .alias_o(alias_wr),
    .port_o (pidx)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic port_wr;
    assign port_wr = wr_en_i && (kind != REG_NONE) && (32'(pidx) == p);

    gpio_port_regs u_regs (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (port_wr),
      .kind_i (kind),
      .alias_i(alias_wr),
      .wdata_i(wdata_i),
      .cfg_o  (cfg_a[p]),
      .oe_o   (oe_a[p]),
      .out_o  (out_a[p])
    );

    assign pad_out_o[p*8 +: 8] = out_a[p];
    assign pad_oe_o[p*8 +: 8]  = cfg_a[p] & oe_a[p];
  end

  gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (in_sync)
  );

  always_comb begin
    rdata_o = '0;
    unique case (kind)
      REG_CFG: rdata_o[7:0] = cfg_a[pidx];
      REG_OE:  rdata_o[7:0] = oe_a[pidx];
      REG_OUT: rdata_o[7:0] = out_a[pidx];
      REG_IN:  rdata_o[7:0] = in_sync[pidx*8 +: 8];
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: tb/gpio_mw_bank_tb.sv
module gpio_mw_bank_tb;
  localparam int NB = 2;
  localparam int NP = NB * 4;
  localparam int NPIN = NP * 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [9:0]      addr = '0;
  logic [15:0]     wdata = '0;
  logic [31:0]     rdata;
  logic [NPIN-1:0] pad_out, pad_oe, pad_in = '0;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] m_reg [NP][3];

  always #2 clk = ~clk;

  gpio_mw_bank #(.NUM_BANKS(NB), .ADDR_W(10)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_out_o(pad_out),
    .pad_oe_o(pad_oe), .pad_in_i(pad_in));

  function automatic logic [9:0] waddr(int p, int k, bit al);
    int b;
    b = (al ? 32'h800 : 0) + (p / 4) * 32'h80 + (p % 4) * 4 + k * 32'h10;
    return 10'(b >> 2);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(string req, logic [9:0] a, logic [7:0] exp);
    addr = a;
    #1;
    check(req, {32'h0, rdata}, {56'h0, exp});
  endtask

  task automatic mwr(int p, int k, bit al, logic [15:0] d);
    wr(waddr(p, k, al), d);
    if (al) m_reg[p][k] = (m_reg[p][k] & ~d[15:8]) | (d[7:0] & d[15:8]);
    else    m_reg[p][k] = d[7:0];
  endtask

  task automatic chk_all(string req);
    logic [NPIN-1:0] e_out, e_oe;
    for (int p = 0; p < NP; p++) begin
      for (int k = 0; k < 3; k++) rd(req, waddr(p, k, 0), m_reg[p][k]);
      e_out[p*8 +: 8] = m_reg[p][2];
      e_oe[p*8 +: 8]  = m_reg[p][0] & m_reg[p][1];
    end
    check({req, " R5 pad_out"}, 64'(pad_out), 64'(e_out));
    check({req, " R5 pad_oe"}, 64'(pad_oe), 64'(e_oe));
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++) for (int k = 0; k < 3; k++) m_reg[p][k] = '0;
    #10 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_all("R1 reset");
    check("R1 pad_oe", 64'(pad_oe), 64'h0);

    // R2 / R4: direct writes to every port and register, then full readback
    for (int p = 0; p < NP; p++)
      for (int k = 0; k < 3; k++)
        mwr(p, k, 0, {8'hFF, 8'((p * 37 + k * 11 + 5) ^ 8'h5A)});
    chk_all("R2 R4 direct");

    // R3: alias sweep over all masks on one output register, with readback at both addresses
    for (int m = 0; m < 256; m++) begin
      mwr(3, 2, 1, {8'(m), 8'((m * 7) ^ 8'hA5)});
      rd("R3 alias out", waddr(3, 2, 0), m_reg[3][2]);
      rd("R3 alias read", waddr(3, 2, 1), m_reg[3][2]);
    end
    for (int m = 0; m < 256; m += 17) begin
      mwr(5, 0, 1, {8'(m), 8'(m ^ 8'h3C)});
      mwr(6, 1, 1, {8'(~m), 8'(m * 3)});
    end
    chk_all("R3 R4 R5 alias mix");

    // R6: two-flop input path, then writes to the input offset are ignored
    for (int v = 0; v < 4; v++) begin
      @(negedge clk);
      pad_in = {NB{32'hC3A5_5A3C ^ (32'h1111_1111 * v)}};
      @(negedge clk);
      rd("R6 one edge", waddr(v, 3, 0), 8'(({NB{32'hC3A5_5A3C ^ (32'h1111_1111 * (v > 0 ? v - 1 : 0))}} >> (v * 8)) & (v > 0 ? 8'hFF : 8'h00)));
      @(negedge clk);
      for (int p = 0; p < NP; p++) rd("R6 two edges", waddr(p, 3, 0), pad_in[p*8 +: 8]);
    end
    wr(waddr(2, 3, 0), 16'hFFFF);
    rd("R6 in write ignored", waddr(2, 3, 0), pad_in[23:16]);
    chk_all("R6 regs untouched");

    // R7: unmapped offsets read zero, writes are dropped
    wr(10'h010, 16'hFFFF);               // kind 4
    wr(10'h01C, 16'hFFFF);               // kind 7
    wr(10'h040, 16'hFFFF);               // bank 2
    wr(waddr(1, 3, 1), 16'hFFFF);        // alias of input
    rd("R7 kind4 read", 10'h010, 8'h00);
    rd("R7 bank2 read", 10'h040, 8'h00);
    rd("R7 alias in read", waddr(1, 3, 1), 8'h00);
    chk_all("R7 no effect");

    // R8: upper read bits zero on a nonzero register
    mwr(0, 2, 0, 16'h00FF);
    addr = waddr(0, 2, 0);
    #1;
    check("R8 upper bits", 64'(rdata[31:8]), 64'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule